// File: doc/BRIEF.md
# EPROM command and address sequencer

This block is the memory-function layer of a single-wire EPROM slave. It sits on top of a byte link that has already recovered whole bytes from the wire. A transaction opens with one command byte. Two target-address bytes follow, least significant byte first. The sequencer then walks a byte pointer through one of two arrays: a 128-byte data field or an 8-byte status field. On read commands it streams array bytes out. At defined boundaries it inserts a CRC-8 byte. On write commands it turns every received byte into one array write.

The 16-bit external pointer always counts upward across the whole 64 KB space. The array only ever sees that pointer ANDed with 007Fh, and for the status field only the low three bits. Reads therefore wrap every 128 bytes. The CRC is built from the masked address, so two start addresses that differ by a multiple of 128 give the same CRC.

Both byte streams use valid/ready handshakes. A byte moves on a rising clock edge where valid and ready are both high. The sequencer never drops `tx_valid` while `tx_ready` is low, and it holds the byte steady, with one exception: a `bus_reset` withdraws the byte. The array port is a plain combinational read with a single-cycle write strobe.

Top module: `eprom_cmd_seq`

## Requirements
- R1: In idle, the block accepts any command byte. The five codes F0h (memory read), C3h (paged read with CRC), 0Fh (memory write), AAh (status read) and 55h (status write) start a transaction. Any other byte is consumed, and the block stays idle.
- R2: After a valid code, the next two accepted bytes form the target address T, low byte first. The array address is T & 7Fh, and `mem_sel` is 0 for the data field. For the status commands, `mem_sel` is 1 and the array address is T & 07h.
- R3: During a read, `tx_data` equals `mem_rdata` for the current array address. Each accepted data byte advances T by one, so the array address wraps from 7Fh to 00h at every 128-byte boundary.
- R4: For F0h, a CRC byte follows the data byte at array address 7Fh.
- R5: For C3h, a CRC byte follows every data byte whose address has its low five bits all ones (the end of each 32-byte page).
- R6: For AAh, a CRC byte follows the data byte at status index 7.
- R7: The CRC uses the polynomial x^8+x^5+x^4+1, shifted LSB first from a zero start. The first span covers the command byte, (T & 7Fh) low byte, (T & 7Fh) high byte (always 00h) and the data. Each later span covers only the data since the previous CRC byte. Start addresses that differ by 128 give equal CRCs.
- R8: During a write, each accepted byte raises `mem_we` for that cycle, with `mem_wdata` equal to the byte, at the masked address and field. T then advances by one.
- R9: After the byte at T = FFFFh, and after its CRC byte if one is due, the block raises neither `tx_valid` nor `rx_ready` until a bus reset.
- R10: While `bus_reset` is high, `rx_ready`, `tx_valid` and `mem_we` are low. From the following cycle the block is idle, with its CRC cleared.
- R11: While `tx_valid` is high and `tx_ready` is low, the next cycle keeps `tx_valid`, `tx_data` and `mem_addr` unchanged, unless `bus_reset` is asserted.
- R12: `rx_ready` is low in read and CRC phases, and `tx_valid` is low in every other phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_reset | input | 1 | Abort of the current transaction, synchronous |
| rx_valid | input | 1 | Incoming byte present |
| rx_ready | output | 1 | Sequencer accepts the incoming byte |
| rx_data | input | 8 | Incoming byte |
| tx_valid | output | 1 | Outgoing byte present |
| tx_ready | input | 1 | Link accepts the outgoing byte |
| tx_data | output | 8 | Outgoing byte (array data or CRC) |
| mem_addr | output | 7 | Masked array address |
| mem_sel | output | 1 | 0 data field, 1 status field |
| mem_we | output | 1 | Array write strobe |
| mem_wdata | output | 8 | Array write data |
| mem_rdata | input | 8 | Array read data, combinational from mem_addr/mem_sel |

## Verification
Two collisions can land in the same cycle. The first is a bus reset and a pending byte handshake. The bench raises `bus_reset` in exactly the cycle where a write byte is offered, and requires `mem_we` to stay low and a later read-back to show the old value. The second is the 128-byte wrap and the page-end CRC. A C3h read that crosses address 7Fh must emit one CRC and then restart at 00h with a fresh span. Every cycle, the reference model's expected handshake, data and write strobe are compared with the ports, so a lost or duplicated byte is seen in the cycle it happens.

// File: rtl/eprom_seq_pkg.sv
package eprom_seq_pkg;

  typedef enum logic [7:0] {
    OP_RD_MEM  = 8'hF0,
    OP_RD_CRC  = 8'hC3,
    OP_WR_MEM  = 8'h0F,
    OP_RD_STAT = 8'hAA,
    OP_WR_STAT = 8'h55
  } opcode_e;

  typedef enum logic [2:0] {
    S_IDLE,
    S_ALO,
    S_AHI,
    S_READ,
    S_CRC,
    S_WRITE,
    S_DONE
  } seq_state_e;

  // One byte through the reflected CRC-8 (x^8+x^5+x^4+1), LSB first.
  function automatic logic [7:0] crc8_byte(input logic [7:0] c, input logic [7:0] d);
    logic [7:0] r;
    r = c;
    for (int i = 0; i < 8; i++) begin
      if (r[0] ^ d[i]) r = (r >> 1) ^ 8'h8C;
      else             r = r >> 1;
    end
    return r;
  endfunction

endpackage

// File: rtl/eprom_crc8.sv
module eprom_crc8
  import eprom_seq_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic          upd,
  input  logic [DW-1:0] din,
  output logic [DW-1:0] crc
);

  always_ff @(posedge clk) begin
    if (!rst_n)     crc <= '0;
    else if (clear) crc <= '0;
    else if (upd)   crc <= crc8_byte(crc, din);
  end

  // A span restart leaves a zero accumulator for the next data byte.
  assert_crc_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (crc == '0));

  // Without an update or clear the accumulator does not drift.
  assert_crc_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!clear && !upd) |=> $stable(crc));

endmodule

// File: rtl/eprom_addr_step.sv
module eprom_addr_step #(
  parameter int EXT_AW   = 16,
  parameter int FIELD_AW = 7,
  parameter int PAGE_AW  = 5,
  parameter int STAT_AW  = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                load_lo,
  input  logic                load_hi,
  input  logic [7:0]          din,
  input  logic                step,
  output logic [EXT_AW-1:0]   ext_addr,
  output logic [FIELD_AW-1:0] field_addr,
  output logic [STAT_AW-1:0]  stat_addr,
  output logic                at_top,
  output logic                page_last,
  output logic                field_last,
  output logic                stat_last
);

  localparam int HI_W = EXT_AW - 8;

  always_ff @(posedge clk) begin
    if (!rst_n)                ext_addr <= '0;
    else if (load_lo)          ext_addr[7:0] <= din;
    else if (load_hi)          ext_addr[EXT_AW-1:8] <= din[HI_W-1:0];
    else if (step && !at_top)  ext_addr <= ext_addr + 1'b1;
  end

  // Masking is a truncation of the external pointer.
  assign field_addr = ext_addr[FIELD_AW-1:0];
  assign stat_addr  = ext_addr[STAT_AW-1:0];
  assign at_top     = &ext_addr;
  assign page_last  = &ext_addr[PAGE_AW-1:0];
  assign field_last = &ext_addr[FIELD_AW-1:0];
  assign stat_last  = &ext_addr[STAT_AW-1:0];

  assert_step_inc_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !at_top && !load_lo && !load_hi) |=> (ext_addr == $past(ext_addr) + 1'b1));

  assert_top_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (at_top && !load_lo && !load_hi) |=> $stable(ext_addr));

endmodule

// File: rtl/eprom_cmd_seq.sv
module eprom_cmd_seq
  import eprom_seq_pkg::*;
#(
  parameter int EXT_AW   = 16,
  parameter int FIELD_AW = 7,
  parameter int PAGE_AW  = 5,
  parameter int STAT_AW  = 3,
  parameter int DW       = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bus_reset,
  input  logic                rx_valid,
  output logic                rx_ready,
  input  logic [DW-1:0]       rx_data,
  output logic                tx_valid,
  input  logic                tx_ready,
  output logic [DW-1:0]       tx_data,
  output logic [FIELD_AW-1:0] mem_addr,
  output logic                mem_sel,
  output logic                mem_we,
  output logic [DW-1:0]       mem_wdata,
  input  logic [DW-1:0]       mem_rdata
);

  localparam logic [EXT_AW-1:0] ADDR_MASK = EXT_AW'((1 << FIELD_AW) - 1);
  localparam logic [7:0]        MASK_LO   = ADDR_MASK[7:0];
  localparam logic [7:0]        MASK_HI   = 8'(ADDR_MASK >> 8);

  seq_state_e st, st_nx;
  opcode_e    op_q;

  logic rx_fire, tx_fire, op_ok, is_wr, is_stat, crc_due;
  logic load_lo, load_hi, step;
  logic crc_clr, crc_upd;
  logic [DW-1:0] crc_din, crc_q;
  logic [EXT_AW-1:0]   ext_addr;
  logic [FIELD_AW-1:0] field_addr;
  logic [STAT_AW-1:0]  stat_addr;
  logic at_top, page_last, field_last, stat_last;

  // ---------------- command decode ----------------
  always_comb begin
    case (rx_data)
      8'hF0, 8'hC3, 8'h0F, 8'hAA, 8'h55: op_ok = 1'b1;
      default:                           op_ok = 1'b0;
    endcase
  end

  assign is_wr   = (op_q == OP_WR_MEM) || (op_q == OP_WR_STAT);
  assign is_stat = (op_q == OP_RD_STAT) || (op_q == OP_WR_STAT);

  always_comb begin
    case (op_q)
      OP_RD_MEM:  crc_due = field_last;
      OP_RD_CRC:  crc_due = page_last;
      OP_RD_STAT: crc_due = stat_last;
      default:    crc_due = 1'b0;
    endcase
  end

  // ---------------- handshakes ----------------
  assign rx_ready = !bus_reset &&
                    (st == S_IDLE || st == S_ALO || st == S_AHI || st == S_WRITE);
  assign tx_valid = !bus_reset && (st == S_READ || st == S_CRC);
  assign rx_fire  = rx_valid && rx_ready;
  assign tx_fire  = tx_valid && tx_ready;

  assign tx_data   = (st == S_CRC) ? crc_q : mem_rdata;
  assign mem_we    = rx_fire && (st == S_WRITE);
  assign mem_wdata = rx_data;
  assign mem_sel   = is_stat;
  assign mem_addr  = is_stat ? FIELD_AW'(stat_addr) : field_addr;

  // ---------------- pointer control ----------------
  assign load_lo = rx_fire && (st == S_ALO);
  assign load_hi = rx_fire && (st == S_AHI);
  assign step    = mem_we ||
                   (tx_fire && ((st == S_READ && !crc_due) || st == S_CRC));

  eprom_addr_step #(
    .EXT_AW  (EXT_AW),
    .FIELD_AW(FIELD_AW),
    .PAGE_AW (PAGE_AW),
    .STAT_AW (STAT_AW)
  ) u_addr (
    .clk       (clk),
    .rst_n     (rst_n),
    .load_lo   (load_lo),
    .load_hi   (load_hi),
    .din       (rx_data),
    .step      (step),
    .ext_addr  (ext_addr),
    .field_addr(field_addr),
    .stat_addr (stat_addr),
    .at_top    (at_top),
    .page_last (page_last),
    .field_last(field_last),
    .stat_last (stat_last)
  );

  // ---------------- CRC span control ----------------
  assign crc_clr = bus_reset || (tx_fire && st == S_CRC);

  always_comb begin
    crc_upd = 1'b0;
    crc_din = tx_data;
    case (st)
      S_IDLE: begin crc_upd = rx_fire && op_ok; crc_din = rx_data;           end
      S_ALO:  begin crc_upd = rx_fire;          crc_din = rx_data & MASK_LO; end
      S_AHI:  begin crc_upd = rx_fire;          crc_din = rx_data & MASK_HI; end
      S_READ: begin crc_upd = tx_fire;          crc_din = mem_rdata;         end
      default: ;
    endcase
  end

  eprom_crc8 #(.DW(DW)) u_crc (
    .clk  (clk),
    .rst_n(rst_n),
    .clear(crc_clr),
    .upd  (crc_upd),
    .din  (crc_din),
    .crc  (crc_q)
  );

  // ---------------- sequencer ----------------
  always_comb begin
    st_nx = st;
    case (st)
      S_IDLE:  if (rx_fire && op_ok) st_nx = S_ALO;
      S_ALO:   if (rx_fire) st_nx = S_AHI;
      S_AHI:   if (rx_fire) st_nx = is_wr ? S_WRITE : S_READ;
      S_READ:  if (tx_fire) begin
                 if (crc_due)     st_nx = S_CRC;
                 else if (at_top) st_nx = S_DONE;
               end
      S_CRC:   if (tx_fire) st_nx = at_top ? S_DONE : S_READ;
      S_WRITE: if (rx_fire && at_top) st_nx = S_DONE;
      default: st_nx = st;
    endcase
    if (bus_reset) st_nx = S_IDLE;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st   <= S_IDLE;
      op_q <= OP_RD_MEM;
    end else begin
      st <= st_nx;
      if (st == S_IDLE && rx_fire && op_ok) op_q <= opcode_e'(rx_data);
    end
  end

  // ---------------- assertions ----------------
  assert_abort_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    bus_reset |=> (st == S_IDLE));

  assert_abort_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    bus_reset |-> (!mem_we && !tx_valid && !rx_ready));

  assert_tx_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready) |=> (bus_reset || (tx_valid && $stable(mem_addr) && $stable(st))));

  assert_one_direction_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !(tx_valid && rx_ready));

  assert_write_handshake_R8: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> (rx_valid && rx_ready));

  assert_done_silent_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_DONE) |-> (!tx_valid && !rx_ready));

endmodule

// File: tb/eprom_cmd_seq_tb.sv
`timescale 1ns/100ps
module eprom_cmd_seq_tb;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_reset = 1'b0;
  logic       rx_valid = 1'b0;
  logic [7:0] rx_data = 8'h00;
  logic       tx_ready = 1'b0;
  logic       rx_ready, tx_valid, mem_sel, mem_we;
  logic [7:0] tx_data, mem_wdata, mem_rdata;
  logic [6:0] mem_addr;

  always #2.5 clk = ~clk;

  logic [7:0] data_mem [128];
  logic [7:0] stat_mem [8];

  assign mem_rdata = mem_sel ? stat_mem[mem_addr[2:0]] : data_mem[mem_addr];

  always @(posedge clk) begin
    if (mem_we) begin
      if (mem_sel) stat_mem[mem_addr[2:0]] = mem_wdata;
      else         data_mem[mem_addr]      = mem_wdata;
    end
  end

  eprom_cmd_seq u_dut (
    .clk(clk), .rst_n(rst_n), .bus_reset(bus_reset),
    .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
    .mem_addr(mem_addr), .mem_sel(mem_sel), .mem_we(mem_we),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
  );

  int vectors = 0;
  int misses  = 0;
  logic [7:0] rxq[$];

  function automatic logic [7:0] ref_crc(input logic [7:0] c, input logic [7:0] d);
    logic [7:0] r;
    r = c;
    for (int i = 0; i < 8; i++) r = (r[0] ^ d[i]) ? ((r >> 1) ^ 8'h8C) : (r >> 1);
    return r;
  endfunction

  task automatic check(input string tag, input string what, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      misses++;
      $display("FAIL %s %s actual=%0h expected=%0h t=%0t", tag, what, act, exp, $time);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  // phase: 0 idle, 1 addr lo, 2 addr hi, 3 read, 4 crc, 5 write, 6 done
  int         m_ph  = 0;
  int         m_ext = 0;
  logic [7:0] m_cmd = 8'h00;
  logic [7:0] m_crc = 8'h00;

  function automatic bit m_status();
    return (m_cmd == 8'hAA) || (m_cmd == 8'h55);
  endfunction
  function automatic int m_addr();
    return m_status() ? (m_ext & 7) : (m_ext & 127);
  endfunction
  function automatic logic [7:0] m_rd();
    return m_status() ? stat_mem[m_ext & 7] : data_mem[m_ext & 127];
  endfunction
  function automatic bit m_due();
    if (m_cmd == 8'hF0) return (m_ext & 127) == 127;
    if (m_cmd == 8'hC3) return (m_ext & 31) == 31;
    if (m_cmd == 8'hAA) return (m_ext & 7) == 7;
    return 1'b0;
  endfunction
  function automatic bit exp_rr();
    return !bus_reset && (m_ph == 0 || m_ph == 1 || m_ph == 2 || m_ph == 5);
  endfunction
  function automatic bit exp_tv();
    return !bus_reset && (m_ph == 3 || m_ph == 4);
  endfunction

  always @(posedge clk) begin
    if (!rst_n || bus_reset) begin
      m_ph = 0; m_crc = 8'h00;
    end else begin
      case (m_ph)
        0: if (rx_valid) begin
             if (rx_data inside {8'hF0, 8'hC3, 8'h0F, 8'hAA, 8'h55}) begin
               m_cmd = rx_data; m_crc = ref_crc(8'h00, rx_data); m_ph = 1;
             end
           end
        1: if (rx_valid) begin
             m_ext = (m_ext & 32'hFF00) | int'(rx_data);
             m_crc = ref_crc(m_crc, rx_data & 8'h7F); m_ph = 2;
           end
        2: if (rx_valid) begin
             m_ext = (int'(rx_data) << 8) | (m_ext & 255);
             m_crc = ref_crc(m_crc, 8'h00);
             m_ph = (m_cmd == 8'h0F || m_cmd == 8'h55) ? 5 : 3;
           end
        3: if (tx_ready) begin
             m_crc = ref_crc(m_crc, m_rd());
             if (m_due()) m_ph = 4;
             else if (m_ext == 65535) m_ph = 6;
             else m_ext++;
           end
        4: if (tx_ready) begin
             m_crc = 8'h00;
             if (m_ext == 65535) m_ph = 6;
             else begin m_ext++; m_ph = 3; end
           end
        5: if (rx_valid) begin
             if (m_ext == 65535) m_ph = 6; else m_ext++;
           end
        default: ;
      endcase
    end
  end

  // ---------------- per-cycle comparison ----------------
  always @(negedge clk) begin
    if (rst_n) begin
      string tag;
      if (bus_reset)                       tag = "R10";
      else if (m_ph == 0)                  tag = "R1";
      else if (m_ph == 1 || m_ph == 2)     tag = "R2";
      else if (m_ph == 3)                  tag = tx_ready ? "R3" : "R11";
      else if (m_ph == 4)                  tag = (m_cmd == 8'hF0) ? "R4" : (m_cmd == 8'hC3) ? "R5" : "R6";
      else if (m_ph == 5)                  tag = "R8";
      else                                 tag = "R9";
      check(tag, "rx_ready", int'(rx_ready), int'(exp_rr()));
      check((m_ph == 3 || m_ph == 4) ? tag : "R12", "tx_valid", int'(tx_valid), int'(exp_tv()));
      check(tag, "mem_we", int'(mem_we), int'(m_ph == 5 && rx_valid && !bus_reset));
      if (exp_tv()) begin
        if (m_ph == 4) check(tag, "crc byte", int'(tx_data), int'(m_crc));
        else begin
          check(tag, "read byte", int'(tx_data), int'(m_rd()));
          check("R2", "mem_addr", int'(mem_addr), m_addr());
          check("R2", "mem_sel", int'(mem_sel), int'(m_status()));
        end
        if (tx_ready) rxq.push_back(tx_data);
      end
      if (m_ph == 5 && rx_valid && !bus_reset) begin
        check("R8", "write addr", int'(mem_addr), m_addr());
        check("R8", "write sel", int'(mem_sel), int'(m_status()));
        check("R8", "write data", int'(mem_wdata), int'(rx_data));
      end
    end
  end

  // ---------------- stimulus tasks ----------------
  task automatic send_byte(input logic [7:0] b);
    bit ok;
    @(posedge clk); #1 rx_valid = 1'b1; rx_data = b;
    do begin
      @(negedge clk); ok = rx_ready;
      @(posedge clk);
    end while (!ok);
    #1 rx_valid = 1'b0;
  endtask

  task automatic start(input logic [7:0] op, input int addr);
    send_byte(op);
    send_byte(8'(addr));
    send_byte(8'(addr >> 8));
  endtask

  task automatic read_n(input int n, input int stall);
    int got = 0;
    int cyc = 0;
    while (got < n) begin
      @(posedge clk); #1 tx_ready = (stall == 0) || ((cyc % stall) != 0);
      cyc++;
      @(negedge clk);
      if (tx_valid && tx_ready) got++;
    end
    @(posedge clk); #1 tx_ready = 1'b0;
  endtask

  task automatic abort();
    @(posedge clk); #1 bus_reset = 1'b1;
    @(posedge clk); #1 bus_reset = 1'b0;
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    misses++;
    $display("FAIL watchdog: run did not finish actual=hung expected=done");
    summary();
    $finish;
  end

  initial begin
    logic [7:0] crc_a, crc_b;
    for (int i = 0; i < 128; i++) data_mem[i] = 8'((i * 37 + 11) ^ (i >> 2));
    for (int i = 0; i < 8; i++)   stat_mem[i] = 8'hE0 + 8'(i * 3);

    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    check("R1", "reset rx_ready", int'(rx_ready), 1);
    check("R12", "reset tx_valid", int'(tx_valid), 0);

    // R1: unknown code is swallowed, then a memory read past the 128-byte end (R3, R4)
    send_byte(8'h12);
    start(8'hF0, 16'h0070);
    read_n(20, 0);
    abort();

    // R5, R7: paged reads from two starts 128 apart give the same CRC
    rxq.delete();
    start(8'hC3, 16'h0005);
    read_n(28, 3);
    crc_a = rxq[$];
    abort();
    rxq.delete();
    start(8'hC3, 16'h0085);
    read_n(28, 0);
    crc_b = rxq[$];
    check("R7", "crc equal across 128 offset", int'(crc_b), int'(crc_a));
    abort();

    // R5: paged read straddling 7Fh -> 00h
    start(8'hC3, 16'h037C);
    read_n(10, 2);
    abort();

    // R8: writes wrapping the data field, then read back
    start(8'h0F, 16'h017E);
    send_byte(8'hA1); send_byte(8'hB2); send_byte(8'hC3);
    abort();
    rxq.delete();
    start(8'hF0, 16'h007E);
    read_n(4, 0);
    check("R8", "readback 7E", int'(rxq[0]), 8'hA1);
    check("R8", "readback 7F", int'(rxq[1]), 8'hB2);
    check("R8", "readback 00", int'(rxq[3]), 8'hC3);
    abort();

    // R6: status write then status read to its CRC
    start(8'h55, 16'h0406);
    send_byte(8'h5A); send_byte(8'h6B);
    abort();
    start(8'hAA, 16'h0083);
    read_n(11, 2);
    abort();

    // R10: bus reset in the same cycle as an offered write byte
    start(8'h0F, 16'h0010);
    @(posedge clk); #1 rx_valid = 1'b1; rx_data = 8'h99; bus_reset = 1'b1;
    @(negedge clk);
    check("R10", "mem_we during abort", int'(mem_we), 0);
    @(posedge clk); #1 rx_valid = 1'b0; bus_reset = 1'b0;
    @(negedge clk);
    check("R10", "idle after abort", int'(rx_ready), 1);
    rxq.delete();
    start(8'hF0, 16'h0010);
    read_n(1, 0);
    check("R10", "write suppressed", int'(rxq[0]), int'(data_mem[16]));
    abort();

    // R9: end of the 64 KB space
    start(8'hF0, 16'hFFFE);
    read_n(3, 0);
    repeat (4) @(negedge clk);
    check("R9", "silent after top", int'(tx_valid || rx_ready), 0);
    abort();
    start(8'hC3, 16'hFFFD);
    read_n(4, 2);
    repeat (3) @(negedge clk);
    check("R9", "silent after top C3", int'(tx_valid || rx_ready), 0);
    abort();

    repeat (3) @(posedge clk);
    summary();
    $finish;
  end

endmodule